// File: doc/BRIEF.md
# Program Counter and Conditional Branch Unit

This block owns the instruction address of a small 16-bit processor. Every cycle it chooses the next fetch address. It either steps forward by one instruction word or loads a branch target. It also keeps the outcome of the most recent compare instruction, which can be one of three values: equal, greater or less.

A conditional branch carries a 2-bit condition code. The branch is taken when that code names the stored outcome. The processor has no zero, carry or sign flags.

The decoder supplies the instruction's 2-bit format field, the condition code and the target address. When a compare instruction retires, the ALU supplies its result together with a write strobe. The block returns the current PC and a combinational branch-taken signal. A stall input freezes all state, and a synchronous reset returns the block to a known start.

Top module: `pc_steer`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `pc` to 0 and the stored compare outcome to equal (code 0). This takes priority over `stall` and every other input.
- R2: Outside reset and stall, a cycle with `br_taken` low advances `pc` by one. The addition wraps modulo 2^16, so 16'hFFFF is followed by 16'h0000.
- R3: While `stall` is high and `rst` is low, `pc` and the stored compare outcome keep their values, even when `br_taken` or `cmp_wr` is high.
- R4: With `fmt` = 2'b10 and `cond` = 2'b00, `br_taken` is high exactly when the stored outcome is equal (code 0). `br_taken` is combinational and is not gated by `stall`.
- R5: With `fmt` = 2'b10 and `cond` = 2'b01, `br_taken` is high exactly when the stored outcome is greater (code 1).
- R6: With `fmt` = 2'b10 and `cond` = 2'b10, `br_taken` is high exactly when the stored outcome is less (code 2).
- R7: `cond` = 2'b11 never raises `br_taken`.
- R8: `fmt` values 2'b00, 2'b01 and 2'b11 never raise `br_taken`. Format 2'b11 is a memory instruction, so it only ever produces the normal increment.
- R9: Outside reset and stall, a cycle with `br_taken` high loads `pc` with `target`.
- R10: When `cmp_wr` is high, `stall` is low and `cmp_res` is 0, 1 or 2, the stored outcome takes the value of `cmp_res` at the edge. In every other non-reset cycle it keeps its value, and `cmp_res` = 3 is ignored.
- R11: A compare result written in a cycle has no effect on `br_taken` in that same cycle. Branches see only the outcome stored at earlier edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Freeze PC and compare outcome |
| fmt | input | 2 | Format field of the current instruction |
| cond | input | 2 | Branch condition code |
| target | input | 16 | Branch target address |
| cmp_wr | input | 1 | A compare instruction retires this cycle |
| cmp_res | input | 2 | Compare result: 0 equal, 1 greater, 2 less |
| pc | output | 16 | Current program counter |
| br_taken | output | 1 | The current instruction is a taken branch |

## Verification
The assertions assume that `rst` is high at the first clock edge and that every input is driven to a known value from then on. The bench drives every input from time zero and changes inputs only a few nanoseconds after a rising edge, so no undefined value ever reaches an edge.

The stimulus deliberately includes the unused `cmp_res` code 3 and the reserved condition code. These let the hold and never-take properties be exercised, not just assumed.

// File: rtl/pc_steer_pkg.sv
package pc_steer_pkg;
   typedef enum logic [1:0] {
      FMT_REG    = 2'b00,
      FMT_IMM    = 2'b01,
      FMT_BRANCH = 2'b10,
      FMT_MEM    = 2'b11
   } fmt_e;

   typedef enum logic [1:0] {
      CC_EQ  = 2'b00,
      CC_GT  = 2'b01,
      CC_LT  = 2'b10,
      CC_RSV = 2'b11
   } cc_e;

   typedef enum logic [1:0] {
      OUT_EQ  = 2'b00,
      OUT_GT  = 2'b01,
      OUT_LT  = 2'b10,
      OUT_BAD = 2'b11
   } cmp_e;
endpackage

// File: rtl/pc_steer_cmp_hold.sv
module pc_steer_cmp_hold
   import pc_steer_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       stall,
   input  logic       wr,
   input  logic [1:0] res,
   output logic [1:0] outcome
);
   cmp_e outcome_q;
   logic load;

   // a result is captured only on a retiring, unstalled compare with a legal code
   assign load = wr && !stall && (cmp_e'(res) != OUT_BAD);

   always_ff @(posedge clk) begin
      if (rst) begin
         outcome_q <= OUT_EQ;
      end else if (load) begin
         outcome_q <= cmp_e'(res);
      end
   end

   assign outcome = outcome_q;
endmodule

// File: rtl/pc_steer_decide.sv
module pc_steer_decide
   import pc_steer_pkg::*;
#(
   parameter bit DECODE_ONEHOT = 1'b1
) (
   input  logic [1:0] fmt,
   input  logic [1:0] cond,
   input  logic [1:0] outcome,
   output logic       take
);
   localparam int NCODE = 4;

   logic is_branch;
   logic match;

   assign is_branch = (fmt_e'(fmt) == FMT_BRANCH);

   generate
      if (DECODE_ONEHOT) begin : g_onehot
         logic [NCODE-1:0] cc_mask;
         logic [NCODE-1:0] out_mask;
         assign cc_mask  = NCODE'(1) << cond;
         assign out_mask = NCODE'(1) << outcome;
         // the top code is reserved on both sides, so it is masked off
         assign match    = |(cc_mask[NCODE-2:0] & out_mask[NCODE-2:0]);
      end else begin : g_case
         always_comb begin
            unique case (cc_e'(cond))
               CC_EQ:   match = (cmp_e'(outcome) == OUT_EQ);
               CC_GT:   match = (cmp_e'(outcome) == OUT_GT);
               CC_LT:   match = (cmp_e'(outcome) == OUT_LT);
               default: match = 1'b0;
            endcase
         end
      end
   endgenerate

   assign take = is_branch && match;
endmodule

// File: rtl/pc_steer_count.sv
module pc_steer_count #(
   parameter int PC_W     = 16,
   parameter int PC_STEP  = 1,
   parameter int PC_RESET = 0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            stall,
   input  logic            take,
   input  logic [PC_W-1:0] target,
   output logic [PC_W-1:0] pc
);
   localparam logic [PC_W-1:0] STEP_V  = PC_W'(PC_STEP);
   localparam logic [PC_W-1:0] RESET_V = PC_W'(PC_RESET);

   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] seq_addr;
   logic [PC_W-1:0] next_addr;

   assign seq_addr  = pc_q + STEP_V;
   assign next_addr = take ? target : seq_addr;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q <= RESET_V;
      end else if (!stall) begin
         pc_q <= next_addr;
      end
   end

   assign pc = pc_q;
endmodule

// File: rtl/pc_steer.sv
module pc_steer #(
   parameter int PC_W          = 16,
   parameter int PC_STEP       = 1,
   parameter int PC_RESET      = 0,
   parameter bit DECODE_ONEHOT = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            stall,
   input  logic [1:0]      fmt,
   input  logic [1:0]      cond,
   input  logic [PC_W-1:0] target,
   input  logic            cmp_wr,
   input  logic [1:0]      cmp_res,
   output logic [PC_W-1:0] pc,
   output logic            br_taken
);
   localparam longint ADDR_SPAN = longint'(1) << PC_W;

   generate
      if (PC_W < 2 || PC_W > 32) begin : g_bad_width
         $error("pc_steer: PC_W must lie in 2..32");
      end
      if (PC_STEP < 1 || longint'(PC_STEP) >= ADDR_SPAN) begin : g_bad_step
         $error("pc_steer: PC_STEP must be at least 1 and below the address span");
      end
      if (PC_RESET < 0 || longint'(PC_RESET) >= ADDR_SPAN) begin : g_bad_reset
         $error("pc_steer: PC_RESET must fit in PC_W bits");
      end
   endgenerate

   logic [1:0] outcome_q;
   logic       take;

   pc_steer_cmp_hold u_hold (
      .clk     (clk),
      .rst     (rst),
      .stall   (stall),
      .wr      (cmp_wr),
      .res     (cmp_res),
      .outcome (outcome_q)
   );

   pc_steer_decide #(
      .DECODE_ONEHOT (DECODE_ONEHOT)
   ) u_decide (
      .fmt     (fmt),
      .cond    (cond),
      .outcome (outcome_q),
      .take    (take)
   );

   pc_steer_count #(
      .PC_W     (PC_W),
      .PC_STEP  (PC_STEP),
      .PC_RESET (PC_RESET)
   ) u_count (
      .clk    (clk),
      .rst    (rst),
      .stall  (stall),
      .take   (take),
      .target (target),
      .pc     (pc)
   );

   assign br_taken = take;
endmodule

// File: rtl/pc_steer_chk.sv
module pc_steer_chk #(
   parameter int PC_W     = 16,
   parameter int PC_STEP  = 1,
   parameter int PC_RESET = 0
) (
   input logic            clk,
   input logic            rst,
   input logic            stall,
   input logic [1:0]      fmt,
   input logic [1:0]      cond,
   input logic [PC_W-1:0] target,
   input logic            cmp_wr,
   input logic [1:0]      cmp_res,
   input logic [PC_W-1:0] pc,
   input logic            br_taken,
   input logic [1:0]      outcome
);
   localparam logic [PC_W-1:0] STEP_V  = PC_W'(PC_STEP);
   localparam logic [PC_W-1:0] RESET_V = PC_W'(PC_RESET);

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (pc == RESET_V && outcome == 2'b00)); // R1

   AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
      (!stall && !br_taken) |=> pc == $past(pc) + STEP_V); // R2

   AST_STALL_PC: assert property (@(posedge clk) disable iff (rst)
      stall |=> $stable(pc)); // R3

   AST_EQ_TAKE: assert property (@(posedge clk) disable iff (rst)
      (fmt == 2'b10 && cond == 2'b00) |-> (br_taken == (outcome == 2'b00))); // R4

   AST_GT_TAKE: assert property (@(posedge clk) disable iff (rst)
      (fmt == 2'b10 && cond == 2'b01) |-> (br_taken == (outcome == 2'b01))); // R5

   AST_LT_TAKE: assert property (@(posedge clk) disable iff (rst)
      (fmt == 2'b10 && cond == 2'b10) |-> (br_taken == (outcome == 2'b10))); // R6

   AST_RSV_NEVER: assert property (@(posedge clk) disable iff (rst)
      (cond == 2'b11) |-> !br_taken); // R7

   AST_FMT_GATE: assert property (@(posedge clk) disable iff (rst)
      (fmt != 2'b10) |-> !br_taken); // R8

   AST_TARGET_LOAD: assert property (@(posedge clk) disable iff (rst)
      (!stall && br_taken) |=> pc == $past(target)); // R9

   AST_CMP_LOAD: assert property (@(posedge clk) disable iff (rst)
      (cmp_wr && !stall && cmp_res != 2'b11) |=> outcome == $past(cmp_res)); // R10

   AST_CMP_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!cmp_wr || stall || cmp_res == 2'b11) |=> $stable(outcome)); // R3 R10

   AST_NO_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
      (cmp_wr && !stall && cmp_res != outcome && cmp_res != 2'b11 && fmt == 2'b10 && cond == cmp_res)
      |-> !br_taken); // R11
endmodule

bind pc_steer pc_steer_chk #(
   .PC_W     (PC_W),
   .PC_STEP  (PC_STEP),
   .PC_RESET (PC_RESET)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .stall    (stall),
   .fmt      (fmt),
   .cond     (cond),
   .target   (target),
   .cmp_wr   (cmp_wr),
   .cmp_res  (cmp_res),
   .pc       (pc),
   .br_taken (br_taken),
   .outcome  (outcome_q)
);

// File: tb/pc_steer_test.sv
module pc_steer_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        stall = 1'b0;
   logic [1:0]  fmt = 2'b00;
   logic [1:0]  cond = 2'b00;
   logic [15:0] target = 16'h0000;
   logic        cmp_wr = 1'b0;
   logic [1:0]  cmp_res = 2'b00;
   logic [15:0] pc;
   logic        br_taken;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [15:0] exp_pc = 16'h0000;
   logic [1:0]  exp_out = 2'b00;

   always #5 clk = ~clk;

   pc_steer uut (
      .clk      (clk),
      .rst      (rst),
      .stall    (stall),
      .fmt      (fmt),
      .cond     (cond),
      .target   (target),
      .cmp_wr   (cmp_wr),
      .cmp_res  (cmp_res),
      .pc       (pc),
      .br_taken (br_taken)
   );

   function automatic logic want_take(logic [1:0] f, logic [1:0] c, logic [1:0] o);
      return (f == 2'b10) && (c != 2'b11) && (c == o);
   endfunction

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // apply one clock edge and update the expected state from the current inputs
   task automatic advance();
      logic tk;
      tk = want_take(fmt, cond, exp_out);
      if (rst) begin
         exp_pc  = 16'h0000;
         exp_out = 2'b00;
      end else if (!stall) begin
         exp_pc = tk ? target : exp_pc + 16'h0001;
         if (cmp_wr && cmp_res != 2'b11) exp_out = cmp_res;
      end
      @(posedge clk);
      #2;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #2000000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0000, 16'h0001);
      finish_run();
   end

   initial begin
      // R1: reset state
      advance();
      advance();
      rst = 1'b0;
      check("R1 pc after reset", pc, 16'h0000);
      fmt = 2'b10; cond = 2'b00; target = 16'h0040;
      #1;
      check("R1 outcome equal after reset", {15'd0, br_taken}, 16'h0001);
      fmt = 2'b00;
      advance();
      check("R2 first step", pc, 16'h0001);

      // R4 R5 R6 R7 R8 R9 R3: sweep stored outcome x format x condition x stall
      for (int o = 0; o < 3; o++) begin
         cmp_wr = 1'b1; cmp_res = 2'(o); fmt = 2'b00; stall = 1'b0;
         advance();
         cmp_wr = 1'b0;
         for (int f = 0; f < 4; f++) begin
            for (int c = 0; c < 4; c++) begin
               for (int s = 0; s < 2; s++) begin
                  fmt = 2'(f); cond = 2'(c); stall = 1'(s);
                  target = 16'h1000 + 16'(o * 256 + f * 16 + c * 2 + s);
                  #1;
                  check("R4 R5 R6 R7 R8 branch decision",
                        {15'd0, br_taken}, {15'd0, want_take(fmt, cond, exp_out)});
                  advance();
                  check("R2 R3 R9 next pc", pc, exp_pc);
               end
            end
         end
      end
      stall = 1'b0;

      // R2: wrap at the top of the address space
      cmp_wr = 1'b1; cmp_res = 2'b00; fmt = 2'b00;
      advance();
      cmp_wr = 1'b0; fmt = 2'b10; cond = 2'b00; target = 16'hFFFF;
      advance();
      check("R9 load top address", pc, 16'hFFFF);
      fmt = 2'b11;
      advance();
      check("R2 R8 wrap to zero", pc, 16'h0000);

      // R11: compare written in the same cycle does not steer the branch
      fmt = 2'b10; cond = 2'b01; target = 16'h0ABC; cmp_wr = 1'b1; cmp_res = 2'b01;
      #1;
      check("R11 same-cycle result unseen", {15'd0, br_taken}, 16'h0000);
      advance();
      check("R11 sequential pc", pc, 16'h0001);
      cmp_wr = 1'b0;
      #1;
      check("R10 greater stored", {15'd0, br_taken}, 16'h0001);
      advance();
      check("R9 taken to target", pc, 16'h0ABC);

      // R10: code 3 is ignored
      fmt = 2'b00; cmp_wr = 1'b1; cmp_res = 2'b11;
      advance();
      cmp_wr = 1'b0; fmt = 2'b10; cond = 2'b01; target = 16'h0123;
      #1;
      check("R10 code 3 ignored", {15'd0, br_taken}, 16'h0001);
      cond = 2'b11;
      #1;
      check("R7 reserved", {15'd0, br_taken}, 16'h0000);

      // R3: a stalled compare is not captured
      fmt = 2'b00; stall = 1'b1; cmp_wr = 1'b1; cmp_res = 2'b10;
      advance();
      check("R3 stalled pc", pc, exp_pc);
      stall = 1'b0; cmp_wr = 1'b0; fmt = 2'b10; cond = 2'b10;
      #1;
      check("R3 R10 stalled compare dropped", {15'd0, br_taken}, 16'h0000);
      cond = 2'b01;
      #1;
      check("R3 outcome kept", {15'd0, br_taken}, 16'h0001);

      // R1: reset in mid-run wins over stall and a pending branch
      cmp_wr = 1'b1; cmp_res = 2'b10; fmt = 2'b00;
      advance();
      cmp_wr = 1'b0; rst = 1'b1; stall = 1'b1; fmt = 2'b10; cond = 2'b10; target = 16'h7777;
      advance();
      rst = 1'b0; stall = 1'b0;
      check("R1 mid-run pc", pc, 16'h0000);
      cond = 2'b00;
      #1;
      check("R1 mid-run outcome equal", {15'd0, br_taken}, 16'h0001);
      fmt = 2'b00;
      advance();
      check("R2 step after reset", pc, exp_pc);

      finish_run();
   end
endmodule